// File: doc/BRIEF.md
# Clock Register Port with Coherent Time Snapshot

This block is the register front end that sits between an already decoded two-wire serial bus and a real-time clock core. The bus receiver hands it one-cycle event pulses: start, stop, an address match together with the transfer direction, a received data byte, and a request for a byte to transmit. The block owns a register pointer over ten locations. Locations 0 to 6 hold time bytes, location 7 is the control byte, location 8 is the charger setting and location 9 is the status flag byte. It turns bus traffic into write strobes toward the clock core and into read data back to the bus.

Time reads come from a seven-byte snapshot buffer rather than from the live counters. The buffer is refreshed on every start, on every stop, and whenever the pointer steps onto location 0. A multibyte read therefore sees one consistent instant even while the clock keeps running. The pointer walks in two separate loops. Locations 0 to 7 form one loop. Locations 8 and 9 form a second loop that can only be entered by loading the pointer directly, and it returns to location 0 after location 9.

A power-good input gates all access. While it is low, the address is not acknowledged, no write strobe is issued and any open transfer is dropped. After power-good rises, access stays closed until it has been high for a programmable number of clock cycles. The same wait applies after reset.

Top module: `rtcRegPort`

## Requirements
- R1: The byte returned on `txData` for pointer value p is snapshot byte p (time byte p is `liveTime[8p+7:8p]` at the last capture) for p in 0..6, `ctrlReg` for p = 7, `trickleReg` for p = 8 and `flagReg` for p = 9.
- R2: Each data byte moved after the pointer is set advances the pointer: 0..6 step up by one, 7 goes to 0, 8 goes to 9, and 9 goes to 0.
- R3: In a write transfer, the first data byte after the address loads the pointer and raises no write strobe. A loaded value above 9 sets the pointer to 0.
- R4: Each later data byte in a write transfer raises `wrEn` in the same cycle as `rxValid`, with `wrAddr` equal to the current pointer and `wrData` equal to `rxData`.
- R5: A start or a stop event copies `liveTime` into the snapshot buffer at that clock edge. The new contents are visible on `txData` from the next cycle.
- R6: When the pointer advances onto location 0, the snapshot is refreshed at the same edge, so the byte read at location 0 reflects the live time at the moment of the wrap.
- R7: Changes on `liveTime` after a capture do not alter time bytes read before the next capture event.
- R8: While `powerGood` is low, `addrAck` and `wrEn` stay low, any open transfer is abandoned, and later data bytes leave the pointer unchanged.
- R9: Access is restored only after `powerGood` has been high for RECOVER_CYCLES consecutive clock edges. This holds after reset and after each power drop.
- R10: After reset the pointer is 0, the snapshot buffer is all zero and no transfer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerGood | input | 1 | Main supply above the fail threshold |
| busStart | input | 1 | Start or repeated start seen (pulse) |
| busStop | input | 1 | Stop seen (pulse) |
| addrMatch | input | 1 | Own device address received (pulse) |
| addrRead | input | 1 | Direction bit with `addrMatch`, 1 = read |
| rxValid | input | 1 | Data byte received from the controller (pulse) |
| rxData | input | 8 | Received data byte |
| txReq | input | 1 | Controller is about to clock out a byte (pulse) |
| liveTime | input | 56 | Running time bytes, byte k at bits 8k+7:8k |
| ctrlReg | input | 8 | Current control byte |
| trickleReg | input | 8 | Current charger setting byte |
| flagReg | input | 8 | Current status flag byte |
| addrAck | output | 1 | Acknowledge the address in this cycle |
| txData | output | 8 | Byte at the current pointer |
| wrEn | output | 1 | Write strobe toward the register owner |
| wrAddr | output | 4 | Target location of the write |
| wrData | output | 8 | Data to write |

## Verification
A wrong pointer appears on the very next `txData` sample or `wrAddr` strobe, because every byte moved is checked against the arithmetic wrap model. That includes the jump from 7 or 9 back to 0, which a single-loop design would get wrong within one byte. A capture that is missed or comes late shows up as stale or premature time bytes within one transfer. The bench changes `liveTime` between each capture event and the read that follows. An off-by-one in the recovery counter changes `addrAck` exactly one cycle early or late around the programmed boundary.

// File: rtl/rtcport_pkg.sv
package rtcport_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 4;

  typedef struct packed {
    logic             capture;
    logic [PTR_W-1:0] regSel;
  } portStrobe_t;
endpackage

// File: rtl/rtcport_ctrl.sv
module rtcport_ctrl
  import rtcport_pkg::*;
#(
  parameter int TIME_REGS      = 7,
  parameter int RECOVER_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              addrMatch,
  input  logic              addrRead,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txReq,
  output logic              addrAck,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output portStrobe_t       strobe
);
  localparam int CTRL_IDX  = TIME_REGS;
  localparam int AUX_FIRST = TIME_REGS + 1;
  localparam int AUX_LAST  = TIME_REGS + 2;
  localparam int CNT_W     = $clog2(RECOVER_CYCLES + 1);

  logic [CNT_W-1:0] recoverCnt;
  logic             accessOk;
  logic [PTR_W-1:0] ptr, nextPtr, loadPtr;
  logic             sessActive, sessRead, needPtr;
  logic             readAdvance, advance;

  // access window
  assign accessOk = powerGood && (recoverCnt == CNT_W'(RECOVER_CYCLES));

  always_ff @(posedge clk) begin
    if (!rstN)                                   recoverCnt <= '0;
    else if (!powerGood)                         recoverCnt <= '0;
    else if (recoverCnt != CNT_W'(RECOVER_CYCLES)) recoverCnt <= recoverCnt + 1'b1;
  end

  // pointer stepping with two loops
  always_comb begin
    if (ptr == PTR_W'(CTRL_IDX) || ptr == PTR_W'(AUX_LAST)) nextPtr = '0;
    else                                                     nextPtr = ptr + 1'b1;
  end

  always_comb begin
    if (rxData > BYTE_W'(AUX_LAST)) loadPtr = '0;
    else                            loadPtr = rxData[PTR_W-1:0];
  end

  assign addrAck     = addrMatch && accessOk;
  assign wrEn        = accessOk && rxValid && sessActive && !sessRead && !needPtr;
  assign wrAddr      = ptr;
  assign wrData      = rxData;
  assign readAdvance = accessOk && txReq && sessActive && sessRead;
  assign advance     = wrEn || readAdvance;

  assign strobe.capture = busStart || busStop || (advance && nextPtr == '0);
  assign strobe.regSel  = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      sessActive <= 1'b0;
      sessRead   <= 1'b0;
      needPtr    <= 1'b0;
    end else if (!accessOk) begin
      sessActive <= 1'b0;
      needPtr    <= 1'b0;
    end else if (busStart || busStop) begin
      sessActive <= 1'b0;
      needPtr    <= 1'b0;
    end else if (addrMatch) begin
      sessActive <= 1'b1;
      sessRead   <= addrRead;
      needPtr    <= !addrRead;
    end else if (rxValid && sessActive && !sessRead && needPtr) begin
      ptr     <= loadPtr;
      needPtr <= 1'b0;
    end else if (advance) begin
      ptr <= nextPtr;
    end
  end

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(AUX_LAST));
  p_ctrl_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !busStart && !busStop && ptr == PTR_W'(CTRL_IDX)) |=> ptr == '0);
  p_aux_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !busStart && !busStop && ptr == PTR_W'(AUX_FIRST)) |=> ptr == PTR_W'(AUX_LAST));
  p_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |-> (!addrAck && !wrEn));
  p_recover_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> !addrAck);
endmodule

// File: rtl/rtcport_data.sv
module rtcport_data
  import rtcport_pkg::*;
#(
  parameter int TIME_REGS = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  portStrobe_t                 strobe,
  input  logic [TIME_REGS*BYTE_W-1:0] liveTime,
  input  logic [BYTE_W-1:0]           ctrlReg,
  input  logic [BYTE_W-1:0]           trickleReg,
  input  logic [BYTE_W-1:0]           flagReg,
  output logic [BYTE_W-1:0]           txData
);
  localparam int CTRL_IDX = TIME_REGS;

  logic [BYTE_W-1:0] snapByte [TIME_REGS];

  for (genvar k = 0; k < TIME_REGS; k++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rstN)              snapByte[k] <= '0;
      else if (strobe.capture) snapByte[k] <= liveTime[k*BYTE_W +: BYTE_W];
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture |=> snapByte[k] == $past(liveTime[k*BYTE_W +: BYTE_W]));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.capture |=> $stable(snapByte[k]));
  end

  always_comb begin
    txData = '0;
    if (int'(strobe.regSel) < TIME_REGS)            txData = snapByte[strobe.regSel];
    else if (int'(strobe.regSel) == CTRL_IDX)       txData = ctrlReg;
    else if (int'(strobe.regSel) == CTRL_IDX + 1)   txData = trickleReg;
    else if (int'(strobe.regSel) == CTRL_IDX + 2)   txData = flagReg;
  end
endmodule

// File: rtl/rtcRegPort.sv
module rtcRegPort
  import rtcport_pkg::*;
#(
  parameter int TIME_REGS      = 7,
  parameter int RECOVER_CYCLES = 250000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        powerGood,
  input  logic                        busStart,
  input  logic                        busStop,
  input  logic                        addrMatch,
  input  logic                        addrRead,
  input  logic                        rxValid,
  input  logic [BYTE_W-1:0]           rxData,
  input  logic                        txReq,
  input  logic [TIME_REGS*BYTE_W-1:0] liveTime,
  input  logic [BYTE_W-1:0]           ctrlReg,
  input  logic [BYTE_W-1:0]           trickleReg,
  input  logic [BYTE_W-1:0]           flagReg,
  output logic                        addrAck,
  output logic [BYTE_W-1:0]           txData,
  output logic                        wrEn,
  output logic [PTR_W-1:0]            wrAddr,
  output logic [BYTE_W-1:0]           wrData
);
  portStrobe_t strobe;

  rtcport_ctrl #(.TIME_REGS(TIME_REGS), .RECOVER_CYCLES(RECOVER_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood),
    .busStart(busStart), .busStop(busStop),
    .addrMatch(addrMatch), .addrRead(addrRead),
    .rxValid(rxValid), .rxData(rxData), .txReq(txReq),
    .addrAck(addrAck), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe)
  );

  rtcport_data #(.TIME_REGS(TIME_REGS)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .liveTime(liveTime), .ctrlReg(ctrlReg), .trickleReg(trickleReg),
    .flagReg(flagReg), .txData(txData)
  );
endmodule

// File: tb/test_rtcRegPort.sv
module test_rtcRegPort;
  localparam int NREC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerGood = 1'b1;
  logic        busStart = 1'b0, busStop = 1'b0, addrMatch = 1'b0, addrRead = 1'b0;
  logic        rxValid = 1'b0, txReq = 1'b0;
  logic [7:0]  rxData = '0;
  logic [55:0] liveTime = '0;
  logic [7:0]  ctrlReg = 8'hC3, trickleReg = 8'hA5, flagReg = 8'h80;
  logic        addrAck, wrEn;
  logic [7:0]  txData, wrData;
  logic [3:0]  wrAddr;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rtcRegPort #(.TIME_REGS(7), .RECOVER_CYCLES(NREC)) i_rtcRegPort (
    .clk(clk), .rstN(rstN), .powerGood(powerGood),
    .busStart(busStart), .busStop(busStop), .addrMatch(addrMatch), .addrRead(addrRead),
    .rxValid(rxValid), .rxData(rxData), .txReq(txReq),
    .liveTime(liveTime), .ctrlReg(ctrlReg), .trickleReg(trickleReg), .flagReg(flagReg),
    .addrAck(addrAck), .txData(txData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] liveSet(input logic [7:0] base);
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = base + 8'(k);
    return v;
  endfunction

  function automatic logic [7:0] expByte(input int p, input logic [55:0] snap);
    if (p < 7)  return snap[p*8 +: 8];
    if (p == 7) return ctrlReg;
    if (p == 8) return trickleReg;
    return flagReg;
  endfunction

  function automatic int stepPtr(input int p);
    if (p == 7 || p == 9) return 0;
    return p + 1;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doStart();
    busStart = 1'b1; cyc(); busStart = 1'b0;
  endtask

  task automatic doStop();
    busStop = 1'b1; cyc(); busStop = 1'b0;
  endtask

  task automatic doAddr(input logic rd, input logic expAck, input string req);
    addrMatch = 1'b1; addrRead = rd; #1;
    check(req, addrAck, expAck);
    cyc(); addrMatch = 1'b0;
  endtask

  task automatic doRx(input logic [7:0] b, input logic expWe, input int expAddr, input string req);
    rxValid = 1'b1; rxData = b; #1;
    check(req, wrEn, expWe);
    if (expWe) begin
      check(req, wrAddr, expAddr);
      check(req, wrData, b);
    end
    cyc(); rxValid = 1'b0;
  endtask

  task automatic doTx(input logic [7:0] exp, input string req);
    txReq = 1'b1; #1;
    check(req, txData, exp);
    cyc(); txReq = 1'b0;
  endtask

  task automatic peekAck(input logic expAck, input string req);
    addrMatch = 1'b1; #1;
    check(req, addrAck, expAck);
    addrMatch = 1'b0; #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    int p;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state, pointer 0 shows snapshot byte 0 = 0
    check("R10 reset txData", txData, 8'h00);
    check("R10 reset wrEn", wrEn, 1'b0);
    // R9: recovery after reset
    repeat (NREC - 1) cyc();
    peekAck(1'b0, "R9 closed before recovery");
    cyc();
    peekAck(1'b1, "R9 open after recovery");

    // R1/R3: pointer load sweep over all 16 values
    for (int v = 0; v < 16; v++) begin
      liveTime = liveSet(8'h10 + 8'(v));
      doStart();
      doAddr(1'b0, 1'b1, "R3 ack write");
      doRx(8'(v), 1'b0, 0, "R3 pointer load no strobe");
      doStart();
      doAddr(1'b1, 1'b1, "R1 ack read");
      p = (v > 9) ? 0 : v;
      doTx(expByte(p, liveTime), "R1 R3 load and read");
      doTx(expByte(stepPtr(p), liveTime), "R2 step after load");
      doStop();
    end

    // R2: full read walk from 8 (second loop then main loop)
    liveTime = liveSet(8'h30);
    doStart(); doAddr(1'b0, 1'b1, "R2 ack");
    doRx(8'd8, 1'b0, 0, "R2 load 8");
    doStart(); doAddr(1'b1, 1'b1, "R2 ack read");
    p = 8;
    for (int n = 0; n < 12; n++) begin
      doTx(expByte(p, liveTime), "R2 walk");
      p = stepPtr(p);
    end
    doStop();

    // R5/R6/R7: coherent snapshot and wrap capture
    liveTime = liveSet(8'h40);
    doStart(); doAddr(1'b0, 1'b1, "R5 ack");
    doRx(8'd0, 1'b0, 0, "R5 load 0");
    doStart();
    snap = liveTime;
    liveTime = liveSet(8'h50);
    doAddr(1'b1, 1'b1, "R7 ack read");
    for (int k = 0; k < 7; k++) doTx(snap[k*8 +: 8], "R7 buffered byte");
    liveTime = liveSet(8'h60);
    doTx(ctrlReg, "R1 control byte");
    liveTime = liveSet(8'h70);
    doTx(8'h60, "R6 wrap captures");
    // R5: stop capture visible without a new start (pointer now 1)
    liveTime = liveSet(8'h90);
    doStop();
    #1;
    check("R5 stop capture", txData, 8'h91);

    // R4: write strobes across both loops
    doStart(); doAddr(1'b0, 1'b1, "R4 ack");
    doRx(8'd6, 1'b0, 0, "R4 load 6");
    doRx(8'hA1, 1'b1, 6, "R4 write 6");
    doRx(8'hA2, 1'b1, 7, "R4 write 7");
    doRx(8'hA3, 1'b1, 0, "R4 write wraps to 0");
    doStop();
    doStart(); doAddr(1'b0, 1'b1, "R4 ack");
    doRx(8'd8, 1'b0, 0, "R4 load 8");
    doRx(8'hB1, 1'b1, 8, "R4 write 8");
    doRx(8'hB2, 1'b1, 9, "R4 write 9");
    doRx(8'hB3, 1'b1, 0, "R4 write after 9");
    doStop();

    // R8: power drop mid write transfer
    doStart(); doAddr(1'b0, 1'b1, "R8 ack");
    doRx(8'd3, 1'b0, 0, "R8 load 3");
    powerGood = 1'b0;
    doRx(8'hC1, 1'b0, 0, "R8 no strobe while blocked");
    doRx(8'h05, 1'b0, 0, "R8 no strobe while blocked");
    doAddr(1'b0, 1'b0, "R8 no ack while blocked");
    doRx(8'h07, 1'b0, 0, "R8 no strobe after dropped address");
    // R9: recovery after power drop
    powerGood = 1'b1;
    repeat (NREC - 1) cyc();
    peekAck(1'b0, "R9 still closed");
    rxValid = 1'b1; rxData = 8'hEE; #1;
    check("R8 R9 session dropped", wrEn, 1'b0);
    rxValid = 1'b0;
    cyc();
    peekAck(1'b1, "R9 reopened");
    // R8: pointer kept at 3 through the blocked period
    liveTime = liveSet(8'hD0);
    doStart(); doAddr(1'b1, 1'b1, "R8 ack read");
    doTx(8'hD3, "R8 pointer unchanged");
    doStop();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule